// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash interface and decides whether a program or erase operation that was already started in the device has finished. A one-cycle `start` pulse captures a valid polling address. The block then issues read cycles at that address over a simple request/ready bus and compares the toggling status bit between pairs of reads. Bit 6 of the returned byte toggles while the device is busy. Bit 5 reports that the device has run past its internal time limit.

Two reads in a row that agree on bit 6 mean the operation is finished. Two reads that disagree lead to a look at bit 5 of the later read. When bit 5 is clear, the block starts a new pair of reads. When bit 5 is set, the block does not give up at once, because the toggling can stop in the same moment the time-limit flag appears. It takes one more pair of reads first. If that pair still disagrees, the block writes the reset command byte 0xF0 and reports failure.

A loop limit set by a parameter ends polls that never settle. The block reports the result as a one-cycle `done` or `fail` pulse, and `busy` covers the whole run.

Top module: `toggle_poll_fsm`

## Requirements
- R1: Out of reset `busy`, `done`, `fail` and `bus_req` are all low.
- R2: A `start` pulse while idle raises `busy` and `bus_req` on the next cycle, with `bus_we` low and `bus_addr` equal to the `poll_addr` value sampled with `start`.
- R3: Each poll step is two reads. If bit 6 of `bus_rdata` agrees between the two reads, `done` pulses and no write is issued.
- R4: If bit 6 differs between the two reads and bit 5 of the second read is 0, another pair of reads follows.
- R5: If bit 6 differs and bit 5 of the second read is 1, one more pair of reads is taken. If bit 6 agrees within that pair, `done` pulses.
- R6: If the extra pair still differs on bit 6, the block issues exactly one write (`bus_we` high) of data 0xF0 to the polling address, and `fail` pulses in the cycle after that write is accepted.
- R7: After `MAX_POLLS` consecutive poll steps that toggle with bit 5 clear, the block takes the failure path of R6 after 2*`MAX_POLLS` reads.
- R8: `done` and `fail` are never high together. Each lasts exactly one cycle, and `busy` is already low while either is high.
- R9: A `start` pulse while `busy` is high is ignored. The run goes on at its original address and ends with its own result.
- R10: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_we` and `bus_addr` hold their values. A transfer completes in the cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| poll_addr | input | AW | Valid address used for every poll read |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data (0xF0 during the reset write, else 0) |
| bus_ready | input | 1 | Transfer accepted / read data valid |
| bus_rdata | input | 8 | Low byte of read data; bits 6 and 5 are used |
| done | output | 1 | One-cycle pulse: operation finished |
| fail | output | 1 | One-cycle pulse: operation failed, reset written |
| busy | output | 1 | High from the cycle after start until the result pulse |

## Verification
A read or write completes on the rising edge where `bus_ready` meets `bus_req`. The next request appears on the outputs one cycle later. `done` or `fail` rises one cycle after the transfer that decides the result, and `busy` falls in that same cycle. The bench's device model raises `bus_ready` on the falling clock edge after a chosen number of wait cycles and samples every output on falling edges, half a cycle away from the edges the design acts on. Each scenario waits for the result pulse and then compares its totals against values worked out by hand from the bit patterns it feeds in: number of reads, number of writes with their data and address, which pulse fired, and how many cycles it lasted.

// File: rtl/toggle_poll_fsm.sv
module toggle_poll_fsm #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_POLLS = 1000,
  localparam int IW       = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] poll_addr,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata,
  output logic          done,
  output logic          fail,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_RC1, S_RC2, S_RST} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic          b6_q;
  logic [IW-1:0] polls;
  logic          done_q, fail_q;

  wire xfer = bus_req && bus_ready;
  wire same = (bus_rdata[6] == b6_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      b6_q   <= 1'b0;
      polls  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= poll_addr;
          polls  <= '0;
          st     <= S_RD1;
        end
        S_RD1: if (xfer) begin
          b6_q <= bus_rdata[6];
          st   <= S_RD2;
        end
        S_RD2: if (xfer) begin
          if (same) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (bus_rdata[5]) begin
            st <= S_RC1;
          end else if (polls == IW'(MAX_POLLS - 1)) begin
            st <= S_RST;
          end else begin
            polls <= polls + 1'b1;
            st    <= S_RD1;
          end
        end
        S_RC1: if (xfer) begin
          b6_q <= bus_rdata[6];
          st   <= S_RC2;
        end
        S_RC2: if (xfer) begin
          if (same) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RST;
          end
        end
        S_RST: if (xfer) begin
          fail_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_RST);
  assign bus_addr  = addr_q;
  assign bus_wdata = bus_we ? DW'(8'hF0) : '0;
  assign busy      = bus_req;
  assign done      = done_q;
  assign fail      = fail_q;

endmodule

module toggle_poll_fsm_chk #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_POLLS = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          done,
  input logic          fail,
  input logic          busy
);

  logic [31:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_cnt <= '0;
    else if (start && !busy) rd_cnt <= '0;
    else if (bus_req && bus_ready && !bus_we) rd_cnt <= rd_cnt + 1;
  end

  a_r1_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !bus_we));
  a_r6_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata[7:0] == 8'hF0));
  a_r6_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_ready) |=> fail);
  a_r7_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 32'(2 * MAX_POLLS + 2));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  a_r8_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

endmodule

bind toggle_poll_fsm toggle_poll_fsm_chk #(.AW(AW), .DW(DW), .MAX_POLLS(MAX_POLLS)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .done(done), .fail(fail), .busy(busy)
);

// File: tb/test_toggle_poll_fsm.sv
`timescale 1ns/1ps
module test_toggle_poll_fsm;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int MP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic          bus_req, bus_we, done, fail, busy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready = 1'b0;
  logic [7:0]    bus_rdata = '0;

  always #2.5 clk = ~clk;

  toggle_poll_fsm #(.AW(AW), .DW(DW), .MAX_POLLS(MP)) i_toggle_poll_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .done(done), .fail(fail), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] script [16];
  int rd_idx, n_wr, lat, wcnt, done_cyc, fail_cyc, cyc;
  logic [DW-1:0] wr_data;
  logic          addr_bad;
  logic [AW-1:0] exp_addr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // device model and monitors, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (done) done_cyc++;
    if (fail) fail_cyc++;
    if (bus_req && bus_addr !== exp_addr) addr_bad = 1'b1;
    if (bus_req && !bus_ready && wcnt >= lat) begin
      bus_ready = 1'b1;
      if (bus_we) begin
        n_wr++;
        wr_data = bus_wdata;
      end else begin
        bus_rdata = script[rd_idx % 16];
        rd_idx++;
      end
    end else begin
      if (bus_ready || !bus_req) wcnt = 0;
      else wcnt++;
      bus_ready = 1'b0;
    end
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic run(input logic [AW-1:0] a, input int l, input bit restart_mid);
    rd_idx = 0; n_wr = 0; done_cyc = 0; fail_cyc = 0; wcnt = 0; lat = l;
    wr_data = '0; addr_bad = 1'b0; exp_addr = a;
    @(negedge clk);
    poll_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0; poll_addr = '0;
    chk(busy && bus_req && !bus_we && bus_addr == a, "R2", int'(busy), 1);
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      poll_addr = a ^ 24'h00FFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000 && !(done || fail); i++) @(negedge clk);
    chk(!busy, "R8", int'(busy), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fail && !bus_req, "R1", int'({busy, done, fail, bus_req}), 0);
  endtask

  task automatic t_stable_now;
    script[0] = 8'h40; script[1] = 8'h40;
    run(24'h000100, 0, 0);
    chk(rd_idx == 2 && done_cyc == 1 && fail_cyc == 0 && n_wr == 0, "R3", rd_idx, 2);
    chk(done_cyc == 1, "R8", done_cyc, 1);
  endtask

  task automatic t_toggle_then_settle;
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h00; script[3] = 8'h40;
    script[4] = 8'h40; script[5] = 8'h40;
    run(24'h00A5A0, 2, 0);
    chk(rd_idx == 6 && done_cyc == 1 && n_wr == 0, "R4", rd_idx, 6);
    chk(!addr_bad, "R10", int'(addr_bad), 0);
  endtask

  task automatic t_recheck_ok;
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h20;
    run(24'h123456, 1, 0);
    chk(rd_idx == 4 && done_cyc == 1 && fail_cyc == 0 && n_wr == 0, "R5", rd_idx, 4);
  endtask

  task automatic t_recheck_fail;
    script[0] = 8'h40; script[1] = 8'h20; script[2] = 8'h00; script[3] = 8'h60;
    run(24'h0000F0, 1, 0);
    chk(rd_idx == 4 && fail_cyc == 1 && done_cyc == 0, "R6", rd_idx, 4);
    chk(n_wr == 1 && wr_data == 16'h00F0, "R6", int'(wr_data), 'hF0);
    chk(!addr_bad, "R6", int'(addr_bad), 0);
    chk(fail_cyc == 1, "R8", fail_cyc, 1);
  endtask

  task automatic t_watchdog;
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
    run(24'h0F0F0F, 0, 0);
    chk(rd_idx == 2 * MP && fail_cyc == 1 && done_cyc == 0, "R7", rd_idx, 2 * MP);
    chk(n_wr == 1 && wr_data == 16'h00F0, "R7", n_wr, 1);
  endtask

  task automatic t_start_busy;
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h00;
    script[4] = 8'h00; script[5] = 8'h00;
    run(24'h00BEEF, 3, 1);
    chk(!addr_bad, "R9", int'(addr_bad), 0);
    chk(rd_idx == 6 && done_cyc == 1 && fail_cyc == 0, "R9", rd_idx, 6);
  endtask

  initial begin
    cyc = 0;
    exp_addr = '0;
    for (int i = 0; i < 16; i++) script[i] = 8'h00;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_stable_now;
    t_toggle_then_settle;
    t_recheck_ok;
    t_recheck_fail;
    t_watchdog;
    t_start_busy;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule